// File: doc/BRIEF.md
# Loadable Odd-Step Up/Down Counter

This block is a fully synchronous 9-bit counter driven by a 2-bit operation code. Each clock edge it either takes an external data word, steps up by three, steps down by five, or keeps its value. All state changes happen on the rising clock edge, and reset is synchronous and active high. No path is asynchronous.

The count wraps modulo 512. Two registered flags report a wrap. The up flag pulses for one cycle when a +3 step passes the top of the range. The down flag pulses for one cycle when a −5 step goes below zero. An even-parity bit is derived from the registered count, so it is valid in the same cycle as the count. The step sizes and the width are parameters. The defaults give the 9-bit, +3/−5 behaviour described here.

Top module: `odd_step_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `count` = 0, `wrap_up` = 0 and `wrap_dn` = 0.
- R2: With `op` = 2'b00 at a rising edge, `count` takes the value of `din` after that edge.
- R3: With `op` = 2'b01 at a rising edge, `count` becomes (count + 3) mod 512.
- R4: With `op` = 2'b10 at a rising edge, `count` becomes (count − 5) mod 512.
- R5: With `op` = 2'b11 at a rising edge, `count` keeps its present value.
- R6: `wrap_up` is 1 for the cycle after an up step from a count of 509 or above, and 0 after an up step from 508 or below.
- R7: `wrap_dn` is 1 for the cycle after a down step from a count of 4 or below, and 0 after a down step from 5 or above.
- R8: After a load or a hold, both `wrap_up` and `wrap_dn` are 0. The two flags are never 1 together.
- R9: `par` makes the total number of ones in {`count`, `par`} even, in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | 00 load, 01 up by 3, 10 down by 5, 11 hold |
| din | input | 9 | Value taken on a load |
| count | output | 9 | Registered count |
| par | output | 1 | Even-parity bit over `count` |
| wrap_up | output | 1 | One-cycle pulse after an up step that wrapped |
| wrap_dn | output | 1 | One-cycle pulse after a down step that wrapped |

## Verification
The up step is tested from low counts and from 508, 509 and 511. These three starting points separate the last step that does not wrap from the first step that does, and they confirm the wrapped remainder. The down step is tested from 5, 4 and 0 for the same reason on the lower edge. Loads of all-zero, all-one and alternating words, with holds placed between steps, show that the flags clear and the count stays put. The parity bit is checked after every step, so it is tried against counts of both odd and even weight.

// File: rtl/odd_step_counter.sv
module odd_step_counter #(
  parameter int WIDTH     = 9,
  parameter int UP_STEP   = 3,
  parameter int DOWN_STEP = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             par,
  output logic             wrap_up,
  output logic             wrap_dn
);

  localparam logic [1:0] OP_LOAD = 2'b00;
  localparam logic [1:0] OP_UP   = 2'b01;
  localparam logic [1:0] OP_DOWN = 2'b10;
  localparam logic [1:0] OP_HOLD = 2'b11;

  localparam logic [WIDTH-1:0] UP_W = WIDTH'(UP_STEP);
  localparam logic [WIDTH-1:0] DN_W = WIDTH'(DOWN_STEP);

  logic [WIDTH:0] sum_ext;
  logic [WIDTH:0] dif_ext;

  assign sum_ext = {1'b0, count} + {1'b0, UP_W};
  assign dif_ext = {1'b0, count} - {1'b0, DN_W};

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      wrap_up <= 1'b0;
      wrap_dn <= 1'b0;
    end else begin
      wrap_up <= 1'b0;
      wrap_dn <= 1'b0;
      case (op)
        OP_LOAD: count <= din;
        OP_UP: begin
          count   <= sum_ext[WIDTH-1:0];
          wrap_up <= sum_ext[WIDTH];
        end
        OP_DOWN: begin
          count   <= dif_ext[WIDTH-1:0];
          wrap_dn <= dif_ext[WIDTH];
        end
        default: count <= count;
      endcase
    end
  end

  assign par = ^count;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !wrap_up && !wrap_dn));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> count == $past(din));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
    op == OP_UP |=> count == WIDTH'($past(count) + UP_W));

  assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
    op == OP_DOWN |=> count == WIDTH'($past(count) - DN_W));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(count));

  assert_carry_R6: assert property (@(posedge clk) disable iff (rst)
    op == OP_UP |=> wrap_up == (count < $past(count)));

  assert_borrow_R7: assert property (@(posedge clk) disable iff (rst)
    op == OP_DOWN |=> wrap_dn == (count > $past(count)));

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD || op == OP_HOLD) |=> (!wrap_up && !wrap_dn));

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(wrap_up && wrap_dn));

  always_comb begin
    assert_parity_R9: assert ($countones({count, par}) % 2 == 0 || $isunknown(count));
  end

endmodule

// File: tb/odd_step_counter_bench.sv
module odd_step_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op  = 2'b11;
  logic [8:0] din = '0;
  logic [8:0] count;
  logic       par, wrap_up, wrap_dn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  odd_step_counter u_odd_step_counter (
    .clk(clk), .rst(rst), .op(op), .din(din),
    .count(count), .par(par), .wrap_up(wrap_up), .wrap_dn(wrap_dn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [1:0] o, input logic [8:0] d);
    @(negedge clk);
    op = o; din = d;
    @(posedge clk); #1;
  endtask

  task automatic chk_all(input string tag, input int ec, input int eu, input int ed);
    int ones;
    chk({tag, " count"}, count, ec);
    chk({tag, " wrap_up"}, wrap_up, eu);
    chk({tag, " wrap_dn"}, wrap_dn, ed);
    ones = $countones(ec);
    chk("R9 parity", par, ones % 2);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cycle(2'b01, 9'd0);
    cycle(2'b01, 9'd0);
    chk_all("R1 reset", 0, 0, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_load;
    cycle(2'b00, 9'h1FF); chk_all("R2 load 511", 511, 0, 0);
    cycle(2'b00, 9'h0AA); chk_all("R2 load 0AA", 170, 0, 0);
    cycle(2'b00, 9'h155); chk_all("R2 load 155", 341, 0, 0);
    cycle(2'b00, 9'h000); chk_all("R2 load 0", 0, 0, 0);
  endtask

  task automatic t_up;
    cycle(2'b00, 9'd0);
    for (int i = 1; i <= 4; i++) begin
      cycle(2'b01, 9'd0); chk_all("R3 up from low", 3 * i, 0, 0);
    end
    cycle(2'b00, 9'd508);
    cycle(2'b01, 9'd0); chk_all("R6 up 508 no wrap", 511, 0, 0);
    cycle(2'b00, 9'd509);
    cycle(2'b01, 9'd0); chk_all("R6 up 509 wraps", 0, 1, 0);
    cycle(2'b00, 9'd511);
    cycle(2'b01, 9'd0); chk_all("R3 up 511 wraps", 2, 1, 0);
    cycle(2'b01, 9'd0); chk_all("R8 up no wrap clears", 5, 0, 0);
  endtask

  task automatic t_down;
    cycle(2'b00, 9'd20);
    for (int i = 1; i <= 3; i++) begin
      cycle(2'b10, 9'd0); chk_all("R4 down", 20 - 5 * i, 0, 0);
    end
    cycle(2'b10, 9'd0); chk_all("R7 down 5 no wrap", 0, 0, 0);
    cycle(2'b10, 9'd0); chk_all("R7 down 0 wraps", 507, 0, 1);
    cycle(2'b00, 9'd4);
    cycle(2'b10, 9'd0); chk_all("R4 down 4 wraps", 511, 0, 1);
    cycle(2'b10, 9'd0); chk_all("R8 down no wrap clears", 506, 0, 0);
  endtask

  task automatic t_hold;
    cycle(2'b00, 9'd510);
    cycle(2'b11, 9'd77); chk_all("R5 hold", 510, 0, 0);
    cycle(2'b01, 9'd0);  chk_all("R6 up 510 wraps", 1, 1, 0);
    cycle(2'b11, 9'd3);  chk_all("R8 hold clears carry", 1, 0, 0);
    cycle(2'b10, 9'd0);  chk_all("R7 down 1 wraps", 508, 0, 1);
    cycle(2'b00, 9'd9);  chk_all("R8 load clears borrow", 9, 0, 0);
    cycle(2'b11, 9'd0);  chk_all("R5 hold again", 9, 0, 0);
  endtask

  task automatic t_mixed;
    exp_cnt = 0;
    cycle(2'b00, 9'd0);
    for (int i = 0; i < 300; i++) begin
      logic [1:0] o;
      int nu, nd;
      o = (i % 7 < 4) ? 2'b01 : ((i % 7 < 6) ? 2'b10 : 2'b11);
      nu = 0; nd = 0;
      if (o == 2'b01) begin nu = (exp_cnt + 3 > 511); exp_cnt = (exp_cnt + 3) % 512; end
      if (o == 2'b10) begin nd = (exp_cnt < 5); exp_cnt = (exp_cnt + 512 - 5) % 512; end
      cycle(o, 9'(i));
      chk_all("R3 R4 mixed", exp_cnt, nu, nd);
    end
  endtask

  initial begin
    t_reset;
    t_load;
    t_up;
    t_down;
    t_hold;
    t_mixed;
    t_reset;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule